// File: doc/BRIEF.md
# Cacheable Window and Coherency Monitor

This block watches the transactions sent to the target flash and decides, for each one, whether its address lies inside the window that the instruction cache may hold. Software gives the window as two page numbers. The start page is widened with zero offset bits and the end page is widened with all-ones offset bits. The span is limited to a parameterised maximum, 8 MB by default, and a longer programmed span is cut back to that maximum.

The block also watches for coherency problems. A valid write that lands in the window while caching is enabled produces a one-cycle write-hit event. A write error from the remote data store produces a one-cycle write-error event. The register file latches these events into status bits and feeds them back. While either status bit is set, the logical cache-active output stays low, and it also stays low until tag/LRU initialisation reports ready. For read lookups that are in range while the cache is active, the block turns the lookup-result strobes into registered hit and miss increment strobes for the counters.

Top module: `cache_range_mon`

## Requirements
- R1: The start bound is the programmed start page followed by PAGE_LSB zero bits. An address equal to this bound counts as in range, and an address one below it does not.
- R2: The end bound is the programmed end page followed by PAGE_LSB one bits. An address equal to this bound counts as in range, and an address one above it does not. This holds at the top of the address space without wrap-around.
- R3: When the widened end bound is greater than start bound + 2^SPAN_LOG2 − 1, that value is used as the end bound instead.
- R4: `in_range_o` is combinational in the same cycle and is high only when `txn_valid_i` is high.
- R5: `wr_hit_evt_o` is high for exactly one cycle, the cycle after a valid write whose address is in range while `cache_en_i` is 1. Writes made with `cache_en_i` at 0, out-of-range writes and reads never raise it.
- R6: `wr_err_evt_o` is high in the cycle after `store_wr_err_i` is high, and low otherwise.
- R7: `cache_active_o` is 1 exactly when `cache_en_i` and `init_done_i` are both 1 and both `wr_hit_sts_i` and `wr_err_sts_i` are 0.
- R8: `hit_inc_o` is high in the cycle after a valid, in-range read with `lookup_hit_i` high while `cache_active_o` is 1.
- R9: `miss_inc_o` is high in the cycle after a valid, in-range read with `lookup_miss_i` high and `lookup_hit_i` low while `cache_active_o` is 1. If both strobes are high, only the hit is counted.
- R10: While reset is asserted and right after it, all registered outputs (`wr_hit_evt_o`, `wr_err_evt_o`, `hit_inc_o`, `miss_inc_o`) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_lo_i | input | ADDR_W-PAGE_LSB | Start page of the window |
| range_hi_i | input | ADDR_W-PAGE_LSB | End page of the window |
| cache_en_i | input | 1 | Software cache enable |
| init_done_i | input | 1 | Tag/LRU initialisation complete |
| wr_hit_sts_i | input | 1 | Latched write-hit status |
| wr_err_sts_i | input | 1 | Latched write-error status |
| txn_valid_i | input | 1 | Transaction valid |
| txn_write_i | input | 1 | Transaction is a write |
| txn_addr_i | input | ADDR_W | Transaction byte address |
| lookup_hit_i | input | 1 | Lookup result: hit |
| lookup_miss_i | input | 1 | Lookup result: miss |
| store_wr_err_i | input | 1 | Write error from remote data store |
| in_range_o | output | 1 | Transaction address is cacheable |
| wr_hit_evt_o | output | 1 | Write-into-window event strobe |
| wr_err_evt_o | output | 1 | Write-error event strobe |
| cache_active_o | output | 1 | Effective cache enable |
| hit_inc_o | output | 1 | Hit counter increment strobe |
| miss_inc_o | output | 1 | Miss counter increment strobe |

## Verification
The bench builds the block with ADDR_W=32 and PAGE_LSB=12, and narrows SPAN_LOG2 to 16 so that a 64 KB limit applies. With that limit the span clamp can be reached by windows only a few pages wide, and the addresses on both sides of the clamped end can be probed directly. A window placed on the last page of the 32-bit space checks that the end-bound arithmetic does not wrap. After the directed cases, a pseudo-random stream of transactions with small page values is compared against the model on every clock.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  typedef struct packed {
    logic wr_hit;
    logic wr_err;
    logic hit;
    logic miss;
  } cmr_strobe_t;
endpackage

// File: rtl/cmr_window.sv
module cmr_window #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 12,
  parameter int SPAN_LOG2 = 23,
  parameter bit CLAMP_EN  = 1'b1,
  localparam int PG_W     = ADDR_W - PAGE_LSB
) (
  input  logic [PG_W-1:0]   lo_pg_i,
  input  logic [PG_W-1:0]   hi_pg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] SPAN_M = {{(ADDR_W-SPAN_LOG2+1){1'b0}}, {SPAN_LOG2{1'b1}}};

  logic [ADDR_W:0] lo_x, hi_x, eff_hi, addr_x;

  assign lo_x   = {1'b0, lo_pg_i, {PAGE_LSB{1'b0}}};
  assign hi_x   = {1'b0, hi_pg_i, {PAGE_LSB{1'b1}}};
  assign addr_x = {1'b0, addr_i};

  generate
    if (CLAMP_EN) begin : g_clamp
      logic [ADDR_W:0] lim;
      assign lim    = lo_x + SPAN_M;  // one spare bit: no wrap at top of space
      assign eff_hi = (hi_x > lim) ? lim : hi_x;
    end else begin : g_noclamp
      assign eff_hi = hi_x;
    end
  endgenerate

  assign hit_o = (addr_x >= lo_x) && (addr_x <= eff_hi);
endmodule

// File: rtl/cmr_strobe_reg.sv
module cmr_strobe_reg
  import cmr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  cmr_strobe_t d_i,
  output cmr_strobe_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/cache_range_mon.sv
module cache_range_mon
  import cmr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 12,
  parameter int SPAN_LOG2 = 23,
  localparam int PG_W     = ADDR_W - PAGE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PG_W-1:0]   range_lo_i,
  input  logic [PG_W-1:0]   range_hi_i,
  input  logic              cache_en_i,
  input  logic              init_done_i,
  input  logic              wr_hit_sts_i,
  input  logic              wr_err_sts_i,
  input  logic              txn_valid_i,
  input  logic              txn_write_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic              lookup_hit_i,
  input  logic              lookup_miss_i,
  input  logic              store_wr_err_i,
  output logic              in_range_o,
  output logic              wr_hit_evt_o,
  output logic              wr_err_evt_o,
  output logic              cache_active_o,
  output logic              hit_inc_o,
  output logic              miss_inc_o
);
  logic        win_hit;
  logic        rd_ok;
  cmr_strobe_t stb_d, stb_q;

  cmr_window #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .SPAN_LOG2(SPAN_LOG2), .CLAMP_EN(1'b1)
  ) u_win (
    .lo_pg_i(range_lo_i), .hi_pg_i(range_hi_i), .addr_i(txn_addr_i), .hit_o(win_hit)
  );

  assign in_range_o     = txn_valid_i & win_hit;
  assign cache_active_o = cache_en_i & init_done_i & ~wr_hit_sts_i & ~wr_err_sts_i;
  assign rd_ok          = in_range_o & ~txn_write_i & cache_active_o;

  always_comb begin
    stb_d        = '0;
    stb_d.wr_hit = in_range_o & txn_write_i & cache_en_i;
    stb_d.wr_err = store_wr_err_i;
    stb_d.hit    = rd_ok & lookup_hit_i;
    stb_d.miss   = rd_ok & lookup_miss_i & ~lookup_hit_i;  // hit wins
  end

  cmr_strobe_reg u_stb (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(stb_d), .q_o(stb_q));

  assign wr_hit_evt_o = stb_q.wr_hit;
  assign wr_err_evt_o = stb_q.wr_err;
  assign hit_inc_o    = stb_q.hit;
  assign miss_inc_o   = stb_q.miss;

  logic [ADDR_W-1:0] win_off;
  assign win_off = txn_addr_i - {range_lo_i, {PAGE_LSB{1'b0}}};

  assert_span_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_range_o |-> (win_off >> SPAN_LOG2) == '0);
  assert_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_range_o |-> txn_valid_i);
  assert_wr_evt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_evt_o |-> $past(txn_valid_i && txn_write_i && cache_en_i));
  assert_err_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_evt_o |-> $past(store_wr_err_i));
  assert_hit_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_inc_o |-> $past(cache_active_o && lookup_hit_i && !txn_write_i));
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hit_inc_o, miss_inc_o}) <= 1);
endmodule

// File: tb/cache_range_mon_tb_top.sv
module cache_range_mon_tb_top;
  localparam int AW = 32, PL = 12, SL = 16, PW = AW - PL;

  logic clk = 0, rst_n = 0;
  logic [PW-1:0] lo = '0, hi = '0;
  logic en = 0, init = 0, shs = 0, ses = 0, v = 0, w = 0, lh = 0, lm = 0, se = 0;
  logic [AW-1:0] a = '0;
  logic inr, whe, wee, act, hinc, minc;
  int checks = 0, errors = 0;
  bit e_whe = 0, e_wee = 0, e_hi = 0, e_mi = 0;

  always #10 clk = ~clk;

  cache_range_mon #(.ADDR_W(AW), .PAGE_LSB(PL), .SPAN_LOG2(SL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .range_lo_i(lo), .range_hi_i(hi),
    .cache_en_i(en), .init_done_i(init), .wr_hit_sts_i(shs), .wr_err_sts_i(ses),
    .txn_valid_i(v), .txn_write_i(w), .txn_addr_i(a),
    .lookup_hit_i(lh), .lookup_miss_i(lm), .store_wr_err_i(se),
    .in_range_o(inr), .wr_hit_evt_o(whe), .wr_err_evt_o(wee),
    .cache_active_o(act), .hit_inc_o(hinc), .miss_inc_o(minc));

  task automatic chk(string req, bit act_v, bit exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b @%0t", req, act_v, exp_v, $time);
    end
  endtask

  function automatic bit m_inr();
    longint lf = longint'(lo) << PL;
    longint hf = (longint'(hi) << PL) + (1 << PL) - 1;
    longint lim = lf + (longint'(1) << SL) - 1;
    if (hf > lim) hf = lim;
    return v && longint'(a) >= lf && longint'(a) <= hf;
  endfunction

  // check last registered expectation, drive new inputs, check comb, predict next
  task automatic step(string tag, bit[PW-1:0] l, bit[PW-1:0] h, bit ce, bit id,
                      bit sh, bit sr, bit tv, bit tw, bit[AW-1:0] ad,
                      bit h_i, bit m_i, bit er);
    bit ia, ir;
    @(negedge clk);
    chk("R5 wr_hit_evt", whe, e_whe);
    chk("R6 wr_err_evt", wee, e_wee);
    chk("R8 hit_inc", hinc, e_hi);
    chk("R9 miss_inc", minc, e_mi);
    lo = l; hi = h; en = ce; init = id; shs = sh; ses = sr;
    v = tv; w = tw; a = ad; lh = h_i; lm = m_i; se = er;
    #1;
    ir = m_inr();
    ia = ce && id && !sh && !sr;
    chk({tag, " in_range"}, inr, ir);
    chk("R7 cache_active", act, ia);
    e_whe = ir && tw && ce;
    e_wee = er;
    e_hi  = ir && !tw && ia && h_i;
    e_mi  = ir && !tw && ia && m_i && !h_i;
  endtask

  initial begin
    #1;
    chk("R10 reset wr_hit_evt", whe, 0);
    chk("R10 reset wr_err_evt", wee, 0);
    chk("R10 reset hit_inc", hinc, 0);
    chk("R10 reset miss_inc", minc, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R2 bounds, window pages 0x10..0x12
    step("R1", 'h10, 'h12, 1, 1, 0, 0, 1, 0, 32'h0001_0000, 1, 0, 0);
    step("R1", 'h10, 'h12, 1, 1, 0, 0, 1, 0, 32'h0000_FFFF, 1, 0, 0);
    step("R2", 'h10, 'h12, 1, 1, 0, 0, 1, 0, 32'h0001_2FFF, 0, 1, 0);
    step("R2", 'h10, 'h12, 1, 1, 0, 0, 1, 0, 32'h0001_3000, 0, 1, 0);
    step("R4", 'h10, 'h12, 1, 1, 0, 0, 0, 0, 32'h0001_1000, 1, 0, 0);
    // R3 clamp: 0x20000 + 64K - 1
    step("R3", 'h20, 'h40, 1, 1, 0, 0, 1, 0, 32'h0002_FFFF, 0, 0, 0);
    step("R3", 'h20, 'h40, 1, 1, 0, 0, 1, 0, 32'h0003_0000, 0, 0, 0);
    // R2 top of space
    step("R2", 'hFFFFF, 'hFFFFF, 1, 1, 0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    step("R1", 'hFFFFF, 'hFFFFF, 1, 1, 0, 0, 1, 0, 32'hFFFF_EFFF, 0, 0, 0);
    // R5 writes
    step("R5", 'h10, 'h12, 1, 1, 0, 0, 1, 1, 32'h0001_1234, 0, 0, 0);
    step("R5", 'h10, 'h12, 1, 1, 0, 0, 0, 0, 32'h0001_1234, 0, 0, 0);
    step("R5", 'h10, 'h12, 0, 1, 0, 0, 1, 1, 32'h0001_1234, 0, 0, 0);
    step("R5", 'h10, 'h12, 1, 1, 0, 0, 1, 1, 32'h0002_0000, 0, 0, 0);
    step("R5", 'h10, 'h12, 1, 1, 0, 0, 1, 1, 32'h0001_1000, 1, 0, 0);
    // R6
    step("R6", 'h10, 'h12, 1, 1, 0, 0, 0, 0, 32'h0, 0, 0, 1);
    step("R6", 'h10, 'h12, 1, 1, 0, 0, 0, 0, 32'h0, 0, 0, 0);
    // R7 / R8 / R9 gating
    step("R7", 'h10, 'h12, 1, 0, 0, 0, 1, 0, 32'h0001_0010, 1, 0, 0);
    step("R7", 'h10, 'h12, 1, 1, 1, 0, 1, 0, 32'h0001_0010, 1, 0, 0);
    step("R7", 'h10, 'h12, 1, 1, 0, 1, 1, 0, 32'h0001_0010, 0, 1, 0);
    step("R7", 'h10, 'h12, 0, 1, 0, 0, 1, 0, 32'h0001_0010, 0, 1, 0);
    step("R9", 'h10, 'h12, 1, 1, 0, 0, 1, 0, 32'h0001_0010, 1, 1, 0);
    step("R9", 'h10, 'h12, 1, 1, 0, 0, 1, 0, 32'h0001_0010, 0, 1, 0);
    step("R8", 'h10, 'h12, 1, 1, 0, 0, 1, 0, 32'h0003_0010, 1, 0, 0);
    for (int i = 0; i < 400; i++) begin
      bit [31:0] r = $urandom;
      step("R4", PW'(r[3:0]), PW'(r[7:4]), r[8]|r[9], r[10]|r[11], r[12]&r[13], r[14]&r[15],
           r[16]|r[17], r[18], {12'h0, r[31:24], 12'h0} | {24'h0, r[23:19], 3'h0},
           r[20], r[21], r[22]&r[23]);
    end
    step("R10", 'h0, 'h0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 0);
    @(negedge clk);
    chk("R5 wr_hit_evt", whe, e_whe);
    chk("R8 hit_inc", hinc, e_hi);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule